// File: doc/BRIEF.md
# Host-Target Mailbox Register Interface

This block is a memory-mapped mailbox between a processor and a host-side console and test harness. It holds two 64-bit registers. The processor writes commands into the to-host register. The host side answers through the from-host register. The processor reaches each register over a 32-bit register bus as a low word and a high word. A command is built by writing the low word into an empty to-host register and then the high word. One cycle after the high word lands, the block decodes the command and carries it out.

A command does one of four things. It sends a byte to the console, it parks a single pending console read, it reports a test exit code, or it is flagged as unsupported. Console output leaves through a one-entry valid/ready byte slot. Once `tx_valid` is high, `tx_byte` holds steady until a cycle with `tx_ready` high takes it. A console-write command that finds the slot still occupied waits in the to-host register, which stays non-zero, until the slot frees. Console input arrives as a plain valid strobe with no back-pressure. A byte that finds no read pending is dropped.

Top module: `hostlink_mailbox`

## Requirements
- R1: After reset, both registers read zero, `tx_valid`, `unsup_pulse`, `fh_partial`, `exit_done` and `exit_pass` are low, and `exit_code` is zero.
- R2: Bus offsets are 0x0 (from-host low word), 0x4 (from-host high word), 0x8 (to-host low word) and 0xC (to-host high word). A low-word to-host write is accepted only when to-host reads zero and no command is outstanding; it then loads the zero-extended word. Otherwise it is dropped, and a following high-word write is ignored too.
- R3: An accepted high-word to-host write ORs the data into bits 63:32 and completes the command. The command executes on the next clock edge, and except while stalled (R5) to-host reads zero from then on.
- R4: A command word holds the device in bits 63:56, the command in bits 55:48 and the payload in bits 47:0. Device 1 command 1 loads payload bits 7:0 into the output slot and sets from-host to {device, command, 48'h100 OR byte}.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_byte` stay unchanged. A console-write command meeting a full slot stays in to-host until the slot can take it. A slot being drained accepts a new byte in the same cycle.
- R6: Device 1 command 0 stores bits 63:48 as a pending read and clears to-host, and leaves from-host unchanged.
- R7: An `rx_valid` byte with a read pending sets from-host to {pending bits 63:48, 48'h100 OR byte} and ends the pending read. With no read pending, the byte is dropped and from-host is unchanged.
- R8: Device 0 command 0 with payload bit 0 set sets `exit_done`, which stays set until reset. It loads `exit_code` with payload bits 47:1, drives `exit_pass` high exactly when that code is zero, and clears to-host.
- R9: Any other device or command, or device 0 command 0 with payload bit 0 clear, gives a one-cycle `unsup_pulse`. It also sets from-host to {device, command, 48'h0} and clears to-host.
- R10: A low-word from-host write loads the zero-extended word and raises `fh_partial`. A high-word from-host write ORs into bits 63:32 and lowers `fh_partial`.
- R11: Reads return the addressed 32-bit word. Any other offset reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| tx_valid | output | 1 | Console output byte available |
| tx_ready | input | 1 | Console takes the byte |
| tx_byte | output | 8 | Console output byte |
| rx_valid | input | 1 | Console input byte strobe |
| rx_byte | input | 8 | Console input byte |
| fh_partial | output | 1 | From-host update in progress |
| unsup_pulse | output | 1 | Unsupported command seen |
| exit_done | output | 1 | Sticky exit request flag |
| exit_pass | output | 1 | Exit code is zero |
| exit_code | output | 47 | Latched exit code |

## Verification
The hardest state to reach is a console-write command stalled behind a full output slot. In that state to-host is legitimately non-zero, so a low-word write must be rejected. The bench holds `tx_ready` low and issues two console writes back to back. While the second one waits, it probes the stalled to-host contents, a rejected low write and the held output byte. It then raises `tx_ready` and checks that the drain and the queued command happen on the same edge. A pending read is driven the same way: stray input bytes go in before and after it, to show they are dropped.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;
  localparam int CMD_W  = 64;
  localparam int WORD_W = 32;
  localparam int PAY_W  = 48;
  localparam int CODE_W = PAY_W - 1;
  localparam int TAG_W  = CMD_W - PAY_W;

  localparam logic [7:0] DEV_SYS = 8'd0;
  localparam logic [7:0] DEV_CON = 8'd1;
  localparam logic [7:0] OP_EXIT = 8'd0;
  localparam logic [7:0] OP_GET  = 8'd0;
  localparam logic [7:0] OP_PUT  = 8'd1;

  typedef enum logic [1:0] {
    K_EXIT = 2'd0,
    K_PUTC = 2'd1,
    K_GETC = 2'd2,
    K_BAD  = 2'd3
  } cmd_kind_e;
endpackage

// File: rtl/hostlink_decode.sv
module hostlink_decode
  import hostlink_pkg::*;
(
  input  logic [CMD_W-1:0]  word_i,
  output cmd_kind_e         kind_o,
  output logic [7:0]        ch_o,
  output logic [CODE_W-1:0] code_o
);
  logic [7:0] dev, op;

  always_comb begin
    dev    = word_i[63:56];
    op     = word_i[55:48];
    ch_o   = word_i[7:0];
    code_o = word_i[PAY_W-1:1];
    kind_o = K_BAD;
    if (dev == DEV_SYS && op == OP_EXIT && word_i[0])
      kind_o = K_EXIT;
    else if (dev == DEV_CON && op == OP_PUT)
      kind_o = K_PUTC;
    else if (dev == DEV_CON && op == OP_GET)
      kind_o = K_GETC;
  end
endmodule

// File: rtl/hostlink_txslot.sv
module hostlink_txslot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              free_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [DATA_W-1:0] tx_data_o
);
  logic              vld_q;
  logic [DATA_W-1:0] dat_q;

  assign free_o     = !vld_q || tx_ready_i;
  assign tx_valid_o = vld_q;
  assign tx_data_o  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (load_i) begin
      vld_q <= 1'b1;
      dat_q <= data_i;
    end else if (tx_ready_i) begin
      vld_q <= 1'b0;
    end
  end

  // R5: an offered byte is held until taken
  p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !tx_ready_i) |=> (vld_q && $stable(dat_q)));

  // R5: the slot is never loaded while a byte is stuck in it
  p_no_overwrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> free_o);
endmodule

// File: rtl/hostlink_mailbox.sv
module hostlink_mailbox
  import hostlink_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int FH_LO  = 0,
  parameter int FH_HI  = 4,
  parameter int TH_LO  = 8,
  parameter int TH_HI  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_byte,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              fh_partial,
  output logic              unsup_pulse,
  output logic              exit_done,
  output logic              exit_pass,
  output logic [46:0]       exit_code
);
  localparam logic [ADDR_W-1:0] A_FHLO = ADDR_W'(FH_LO);
  localparam logic [ADDR_W-1:0] A_FHHI = ADDR_W'(FH_HI);
  localparam logic [ADDR_W-1:0] A_THLO = ADDR_W'(TH_LO);
  localparam logic [ADDR_W-1:0] A_THHI = ADDR_W'(TH_HI);

  logic [CMD_W-1:0]  tohost_q, fromhost_q;
  logic [TAG_W-1:0]  pend_tag_q;
  logic              pend_v_q, allow_q, armed_q, partial_q, unsup_q, done_q;
  logic [CODE_W-1:0] code_q;

  cmd_kind_e         kind;
  logic [7:0]        cmd_ch;
  logic [CODE_W-1:0] cmd_code;
  logic              slot_free, exec, rx_take;
  logic              we_fhlo, we_fhhi, we_thlo, we_thhi;

  hostlink_decode u_decode (
    .word_i (tohost_q),
    .kind_o (kind),
    .ch_o   (cmd_ch),
    .code_o (cmd_code)
  );

  hostlink_txslot #(.DATA_W(8)) u_txslot (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (exec && kind == K_PUTC),
    .data_i     (cmd_ch),
    .free_o     (slot_free),
    .tx_valid_o (tx_valid),
    .tx_ready_i (tx_ready),
    .tx_data_o  (tx_byte)
  );

  assign we_fhlo = reg_wr && reg_addr == A_FHLO;
  assign we_fhhi = reg_wr && reg_addr == A_FHHI;
  assign we_thlo = reg_wr && reg_addr == A_THLO;
  assign we_thhi = reg_wr && reg_addr == A_THHI;

  // a console write waits for room in the output slot
  assign exec    = armed_q && (kind != K_PUTC || slot_free);
  assign rx_take = rx_valid && pend_v_q && !exec;

  always_comb begin
    unique case (reg_addr)
      A_FHLO:  reg_rdata = fromhost_q[31:0];
      A_FHHI:  reg_rdata = fromhost_q[63:32];
      A_THLO:  reg_rdata = tohost_q[31:0];
      A_THHI:  reg_rdata = tohost_q[63:32];
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tohost_q   <= '0;
      fromhost_q <= '0;
      pend_tag_q <= '0;
      pend_v_q   <= 1'b0;
      allow_q    <= 1'b0;
      armed_q    <= 1'b0;
      partial_q  <= 1'b0;
      unsup_q    <= 1'b0;
      done_q     <= 1'b0;
      code_q     <= '0;
    end else begin
      unsup_q <= 1'b0;

      if (we_thlo) begin
        if (tohost_q == '0 && !armed_q) begin
          allow_q  <= 1'b1;
          tohost_q <= {32'd0, reg_wdata};
        end else begin
          allow_q  <= 1'b0;
        end
      end
      if (we_thhi && allow_q) begin
        tohost_q[63:32] <= tohost_q[63:32] | reg_wdata;
        armed_q         <= 1'b1;
        allow_q         <= 1'b0;
      end

      if (we_fhlo) begin
        fromhost_q <= {32'd0, reg_wdata};
        partial_q  <= 1'b1;
      end
      if (we_fhhi) begin
        fromhost_q[63:32] <= fromhost_q[63:32] | reg_wdata;
        partial_q         <= 1'b0;
      end

      if (rx_take) begin
        fromhost_q <= {pend_tag_q, 40'd1, rx_byte};
        pend_v_q   <= 1'b0;
      end

      if (exec) begin
        armed_q  <= 1'b0;
        tohost_q <= '0;
        unique case (kind)
          K_PUTC: fromhost_q <= {tohost_q[63:48], 40'd1, cmd_ch};
          K_GETC: begin
            pend_tag_q <= tohost_q[63:48];
            pend_v_q   <= 1'b1;
          end
          K_EXIT: begin
            done_q <= 1'b1;
            code_q <= cmd_code;
          end
          default: begin
            unsup_q    <= 1'b1;
            fromhost_q <= {tohost_q[63:48], 48'd0};
          end
        endcase
      end
    end
  end

  assign fh_partial  = partial_q;
  assign unsup_pulse = unsup_q;
  assign exit_done   = done_q;
  assign exit_pass   = done_q && code_q == '0;
  assign exit_code   = code_q;

  // R3: an executed command leaves to-host empty
  p_clear_after_exec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> tohost_q == '0);

  // R8: the exit flag never falls outside reset
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);

  // R9: unsupported indication lasts one cycle
  p_unsup_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_q |=> !unsup_q);

  // R10: a high-word from-host write ends the partial update
  p_partial_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we_fhhi |=> !partial_q);

  // R2: a rejected low write leaves to-host unchanged
  p_reject_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_thlo && tohost_q != '0 && !armed_q && !exec) |=> $stable(tohost_q));
endmodule

// File: tb/hostlink_mailbox_bench.sv
module hostlink_mailbox_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_valid, tx_ready = 1'b1;
  logic [7:0]  tx_byte;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        fh_partial, unsup_pulse, exit_done, exit_pass;
  logic [46:0] exit_code;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #2 clk = ~clk;

  hostlink_mailbox u_hostlink_mailbox (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_byte(tx_byte), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .fh_partial(fh_partial), .unsup_pulse(unsup_pulse),
    .exit_done(exit_done), .exit_pass(exit_pass), .exit_code(exit_code)
  );

  localparam int NV = 6;
  localparam logic [63:0] V_CMD [NV] = '{
    64'h0101_0000_0000_0041, 64'h0101_0000_1234_56FF, 64'h0507_0000_0000_0003,
    64'h0109_0000_0000_0022, 64'h0000_0000_0000_0010, 64'h0003_0000_0000_0001};
  localparam logic [63:0] V_FH [NV] = '{
    64'h0101_0000_0000_0141, 64'h0101_0000_0000_01FF, 64'h0507_0000_0000_0000,
    64'h0109_0000_0000_0000, 64'h0000_0000_0000_0000, 64'h0003_0000_0000_0000};
  localparam bit V_PUT [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd64(input logic [3:0] a, output logic [63:0] d);
    logic [31:0] lo, hi;
    rd(a, lo);
    rd(a + 4'd4, hi);
    d = {hi, lo};
  endtask

  // issues both halves; returns at the negedge just after execution
  task automatic cmd(input logic [63:0] w);
    wr(4'h8, w[31:0]);
    wr(4'hC, w[63:32]);
    @(negedge clk);
  endtask

  task automatic rx(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] v;
    logic [31:0] w;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd64(4'h0, v); chk("R1 fromhost", v, 64'h0);
    rd64(4'h8, v); chk("R1 tohost", v, 64'h0);
    chk("R1 outputs", {62'd0, tx_valid, unsup_pulse}, 64'h0);
    chk("R1 exit", {fh_partial, exit_done, exit_pass, exit_code}, 64'h0);

    // R4, R9, R3: vector table
    for (int i = 0; i < NV; i++) begin
      cmd(V_CMD[i]);
      chk(V_PUT[i] ? "R4 tx_valid" : "R9 tx_valid", {63'd0, tx_valid}, {63'd0, V_PUT[i]});
      if (V_PUT[i]) chk("R4 tx_byte", {56'd0, tx_byte}, {56'd0, V_CMD[i][7:0]});
      chk("R9 unsup_pulse", {63'd0, unsup_pulse}, {63'd0, !V_PUT[i]});
      rd64(4'h0, v); chk(V_PUT[i] ? "R4 fromhost" : "R9 fromhost", v, V_FH[i]);
      rd64(4'h8, v); chk("R3 tohost cleared", v, 64'h0);
      @(negedge clk);
      chk("R9 pulse one cycle", {63'd0, unsup_pulse}, 64'h0);
    end

    // R5, R2: back-pressure and rejected writes
    tx_ready = 1'b0;
    cmd(64'h0101_0000_0000_0078);
    chk("R5 first byte", {55'd0, tx_valid, tx_byte}, {55'd0, 1'b1, 8'h78});
    cmd(64'h0101_0000_0000_0079);
    rd64(4'h8, v); chk("R5 stalled tohost", v, 64'h0101_0000_0000_0079);
    chk("R5 byte held", {55'd0, tx_valid, tx_byte}, {55'd0, 1'b1, 8'h78});
    wr(4'h8, 32'h0000_0055);
    rd(4'h8, w); chk("R2 low write rejected", {32'd0, w}, 64'h79);
    tx_ready = 1'b1;
    @(negedge clk);
    chk("R5 drain and refill", {55'd0, tx_valid, tx_byte}, {55'd0, 1'b1, 8'h79});
    rd64(4'h8, v); chk("R5 tohost after refill", v, 64'h0);
    @(negedge clk);
    chk("R5 slot empties", {63'd0, tx_valid}, 64'h0);
    wr(4'hC, 32'h0101_0000);
    @(negedge clk);
    rd64(4'h8, v); chk("R2 lone high write ignored", v, 64'h0);
    chk("R2 no output", {63'd0, tx_valid}, 64'h0);

    // R7, R6: pending read
    rd64(4'h0, v);
    rx(8'h33);
    rd64(4'h0, w == 0 ? v : v); // keep v as prior value
    begin
      logic [63:0] v2;
      rd64(4'h0, v2); chk("R7 stray byte dropped", v2, 64'h0101_0000_0000_0179);
    end
    cmd(64'h0100_0000_0000_0000);
    rd64(4'h8, v); chk("R6 tohost cleared", v, 64'h0);
    rd64(4'h0, v); chk("R6 fromhost unchanged", v, 64'h0101_0000_0000_0179);
    rx(8'h5A);
    rd64(4'h0, v); chk("R7 byte delivered", v, 64'h0100_0000_0000_015A);
    rx(8'h77);
    rd64(4'h0, v); chk("R7 second byte dropped", v, 64'h0100_0000_0000_015A);

    // R10 from-host writes
    wr(4'h0, 32'hDEAD_BEEF);
    chk("R10 partial set", {63'd0, fh_partial}, 64'h1);
    rd64(4'h0, v); chk("R10 low replaces", v, 64'h0000_0000_DEAD_BEEF);
    wr(4'h4, 32'h0000_00F0);
    chk("R10 partial clear", {63'd0, fh_partial}, 64'h0);
    rd64(4'h0, v); chk("R10 high ORed", v, 64'h0000_00F0_DEAD_BEEF);

    // R11 unmapped offset
    rd(4'h2, w); chk("R11 unmapped read", {32'd0, w}, 64'h0);
    wr(4'h2, 32'hFFFF_FFFF);
    rd64(4'h0, v); chk("R11 unmapped write from-host", v, 64'h0000_00F0_DEAD_BEEF);
    rd64(4'h8, v); chk("R11 unmapped write to-host", v, 64'h0);

    // R8 exit
    cmd(64'h0000_0000_0000_0001);
    chk("R8 pass exit", {exit_done, exit_pass, 15'd0, exit_code}, {2'b11, 62'd0});
    rd64(4'h8, v); chk("R8 tohost cleared", v, 64'h0);
    cmd(64'h0000_0000_0000_000B);
    chk("R8 fail exit", {exit_done, exit_pass, 15'd0, exit_code}, {2'b10, 62'd5});
    cmd(64'h0101_0000_0000_0021);
    chk("R8 done sticky", {63'd0, exit_done}, 64'h1);

    finish_run();
  end
endmodule